// File: doc/BRIEF.md
# Active Priority Tracker with Non-Maskable Interrupt Flag

This block records which priority levels currently hold an active virtual interrupt, with one bitmap per interrupt group (group 0 and group 1) and one extra non-maskable-interrupt (NMI) active flag. When an interrupt is acknowledged, the surrounding logic raises an activate request carrying the group, the priority and the NMI marking. When an interrupt is ended, it raises a priority-drop request. The block updates its bitmaps and reports which level the drop released. The running priority, the most urgent level now active, is always visible at the outputs. A plain write port loads whole bitmap words, and a read port returns them.

The number of implemented priority bits is the parameter `PRIO_BITS`. It sets the number of levels to 2^PRIO_BITS and groups the bitmap into 32-bit words. The caller applies any group binary-point masking before it presents a priority. The parameter `NMI_EN` turns NMI support on or off. When NMI support is on, an active NMI overrides every bitmap bit: the running priority reads as the highest level, and the next drop releases the NMI before any ordinary level. The NMI flag belongs to word 0 of group 1 and is carried as bit 32 on the write and read ports.

Top module: `act_prio_tracker`

## Requirements
- R1: After reset, every bitmap word reads 0, the NMI flag reads 0, `rpr` is 0xFF and `rpr_nmi` is 0.
- R2: An activate that is not an effective NMI sets bitmap bit index `i = act_prio >> (8 - PRIO_BITS)` of group `act_grp`. That bit appears in word `i/32` at bit `i%32` of the read port.
- R3: With `NMI_EN=1`, an activate with `act_nmi=1` sets only the NMI flag (read bit 32 of group 1, word 0) and changes no bitmap bit, whatever `act_grp` is.
- R4: With the NMI flag clear, `rpr` equals `i << (8 - PRIO_BITS)` for the lowest index `i` set in either group, or 0xFF when no bit is set.
- R5: While the NMI flag is set, `rpr` reads 0x00 and `rpr_nmi` reads 1, whatever the bitmaps hold.
- R6: A drop while the NMI flag is set reports `drop_hit=1`, `drop_nmi=1` and `drop_prio=0xFF` in the same cycle. It clears only the NMI flag.
- R7: A drop with the NMI flag clear and some bit set clears the lowest set index. At equal index, group 0 is cleared before group 1. The drop reports `drop_hit=1`, `drop_nmi=0`, `drop_grp` as the cleared group (0 or 1) and `drop_prio = i << (8 - PRIO_BITS)`.
- R8: A drop with nothing active reports `drop_hit=0`, `drop_nmi=0` and `drop_prio=0xFF`, and leaves the state unchanged.
- R9: A write stores `wr_data[31:0]` into word `wr_word` of group `wr_grp`. Bit 32 loads the NMI flag only when `NMI_EN=1` and the target is group 1, word 0. Otherwise bit 32 is discarded.
- R10: With `NMI_EN=0`, `act_nmi` has no special effect. The activate sets its bitmap bit as in R2, and `rpr_nmi` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_valid | input | 1 | Activate request |
| act_grp | input | 1 | Group of the activated interrupt (0 or 1) |
| act_prio | input | 8 | Group-masked priority of the activated interrupt |
| act_nmi | input | 1 | Activated interrupt is an NMI |
| drop_req | input | 1 | Priority-drop request |
| drop_hit | output | 1 | The drop released an active level or the NMI |
| drop_grp | output | 1 | Group whose ordinary bit the drop cleared |
| drop_nmi | output | 1 | The drop released the NMI flag |
| drop_prio | output | 8 | Priority released by the drop, 0xFF for the NMI or for nothing |
| wr_en | input | 1 | Bitmap word write |
| wr_grp | input | 1 | Group of the written word |
| wr_word | input | max(1, clog2(NWORDS)) | Index of the written word |
| wr_data | input | 33 | Word value; bit 32 is the NMI flag |
| rd_grp | input | 1 | Group of the read word |
| rd_word | input | max(1, clog2(NWORDS)) | Index of the read word |
| rd_data | output | 33 | Word value; bit 32 is the NMI flag for group 1, word 0 |
| rpr | output | 8 | Running priority |
| rpr_nmi | output | 1 | Running priority is held by an NMI |

## Verification
The assertions assume that an activate and a drop never arrive in the same cycle. Properties about the state that follows an activate or a drop also assume that no write lands in that same cycle, because a write overrides the word it targets. The bench drives activates, drops and writes as separate one-cycle pulses from tasks, so each operation completes before the next begins, and the checked consequences are never confounded. Drop results are sampled while the request is still high, and state is sampled one full cycle later.

// File: rtl/apt_pkg.sv
package apt_pkg;

  // Bitmap index of a group-masked priority for PRIO_BITS implemented bits
  function automatic int unsigned prio_to_idx(input logic [7:0] p, input int unsigned pbits);
    return int'(p >> (8 - pbits));
  endfunction

  // Priority value represented by a bitmap index
  function automatic logic [7:0] idx_to_prio(input int unsigned idx, input int unsigned pbits);
    logic [15:0] t;
    t = 16'(idx) << (8 - pbits);
    return t[7:0];
  endfunction

  function automatic int unsigned word_width(input int unsigned nwords);
    return (nwords > 1) ? $clog2(nwords) : 1;
  endfunction

endpackage

// File: rtl/apt_lsb_find.sv
module apt_lsb_find #(
  parameter int W  = 32,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  // Scan downward so that the lowest set position is the one left standing
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/apt_bank.sv
module apt_bank #(
  parameter int NWORDS = 1,
  parameter int IDXW   = 5,
  parameter int WW     = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [IDXW-1:0]      set_idx,
  input  logic                 clr_en,
  input  logic [IDXW-1:0]      clr_idx,
  input  logic                 wr_en,
  input  logic [WW-1:0]        wr_word,
  input  logic [31:0]          wr_data,
  output logic [NWORDS*32-1:0] bits
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits <= '0;
    end else begin
      if (set_en) bits[set_idx] <= 1'b1;
      if (clr_en) bits[clr_idx] <= 1'b0;
      // A write replaces its whole word, overriding a same-cycle set or clear
      for (int w = 0; w < NWORDS; w++) begin
        if (wr_en && (int'(wr_word) == w)) bits[w*32 +: 32] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/act_prio_tracker.sv
module act_prio_tracker
  import apt_pkg::*;
#(
  parameter int PRIO_BITS = 5,
  parameter bit NMI_EN    = 1'b1,
  localparam int NLVL     = 1 << PRIO_BITS,
  localparam int NWORDS   = (NLVL + 31) / 32,
  localparam int WW       = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_valid,
  input  logic          act_grp,
  input  logic [7:0]    act_prio,
  input  logic          act_nmi,
  input  logic          drop_req,
  output logic          drop_hit,
  output logic          drop_grp,
  output logic          drop_nmi,
  output logic [7:0]    drop_prio,
  input  logic          wr_en,
  input  logic          wr_grp,
  input  logic [WW-1:0] wr_word,
  input  logic [32:0]   wr_data,
  input  logic          rd_grp,
  input  logic [WW-1:0] rd_word,
  output logic [32:0]   rd_data,
  output logic [7:0]    rpr,
  output logic          rpr_nmi
);
  localparam int IDXW = PRIO_BITS;

  // Named internal events, also observed by the checker
  logic                 act_is_nmi;
  logic                 act_set_ord;
  logic [IDXW-1:0]      act_idx;
  logic                 nmi_q;
  logic                 any_ord;
  logic [IDXW-1:0]      low_idx;
  logic                 low_in_g0;
  logic                 drop_clear_nmi;
  logic                 drop_clear_ord;
  logic                 wr_nmi_word;
  logic [NWORDS*32-1:0] bm [2];
  logic [NLVL-1:0]      combined;

  assign act_is_nmi  = act_valid && act_nmi && NMI_EN;
  assign act_set_ord = act_valid && !act_is_nmi;
  assign act_idx     = IDXW'(prio_to_idx(act_prio, PRIO_BITS));

  for (genvar g = 0; g < 2; g++) begin : g_bank
    apt_bank #(
      .NWORDS (NWORDS),
      .IDXW   (IDXW),
      .WW     (WW)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (act_set_ord && (act_grp == g[0])),
      .set_idx (act_idx),
      .clr_en  (drop_clear_ord && ((g == 0) ? low_in_g0 : !low_in_g0)),
      .clr_idx (low_idx),
      .wr_en   (wr_en && (wr_grp == g[0])),
      .wr_word (wr_word),
      .wr_data (wr_data[31:0]),
      .bits    (bm[g])
    );
  end

  assign combined = bm[0][NLVL-1:0] | bm[1][NLVL-1:0];

  apt_lsb_find #(.W(NLVL)) u_find (
    .vec   (combined),
    .found (any_ord),
    .idx   (low_idx)
  );

  assign low_in_g0      = bm[0][low_idx];
  assign drop_clear_nmi = drop_req && nmi_q;
  assign drop_clear_ord = drop_req && !nmi_q && any_ord;
  assign wr_nmi_word    = wr_en && wr_grp && (wr_word == '0);

  // NMI active flag, owned by group 1 word 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q <= 1'b0;
    end else if (NMI_EN) begin
      if (wr_nmi_word)         nmi_q <= wr_data[32];
      else if (drop_clear_nmi) nmi_q <= 1'b0;
      else if (act_is_nmi)     nmi_q <= 1'b1;
    end
  end

  // Drop result, valid in the cycle of the request
  assign drop_hit  = drop_req && (nmi_q || any_ord);
  assign drop_nmi  = drop_clear_nmi;
  assign drop_grp  = drop_clear_ord && !low_in_g0;
  assign drop_prio = drop_clear_ord ? idx_to_prio(int'(low_idx), PRIO_BITS) : 8'hFF;

  // Running priority
  always_comb begin
    if (nmi_q)        rpr = 8'h00;
    else if (any_ord) rpr = idx_to_prio(int'(low_idx), PRIO_BITS);
    else              rpr = 8'hFF;
  end
  assign rpr_nmi = nmi_q;

  // Word readback
  always_comb begin
    rd_data = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (int'(rd_word) == w) rd_data[31:0] = bm[rd_grp][w*32 +: 32];
    end
    if (rd_grp && (rd_word == '0)) rd_data[32] = nmi_q;
  end

endmodule

// File: rtl/act_prio_tracker_chk.sv
module act_prio_tracker_chk #(
  parameter int PRIO_BITS = 5,
  parameter bit NMI_EN    = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       act_valid,
  input logic       act_nmi,
  input logic [7:0] act_prio,
  input logic       drop_req,
  input logic       drop_hit,
  input logic       drop_nmi,
  input logic [7:0] drop_prio,
  input logic       wr_en,
  input logic [7:0] rpr,
  input logic       rpr_nmi,
  input logic       any_ord
);
  localparam logic [7:0] PMASK = 8'(8'hFF << (8 - PRIO_BITS));

  // input assumption: activate and drop are exclusive
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_valid && drop_req));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (rpr == 8'hFF && !rpr_nmi));

  // R2
  act_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !(act_nmi && NMI_EN) && !drop_req && !wr_en)
      |=> (rpr_nmi || rpr <= ($past(act_prio) & PMASK)));

  // R5
  nmi_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_nmi && NMI_EN && !drop_req && !wr_en)
      |=> (rpr == 8'h00 && rpr_nmi));

  // R3
  nmi_ord_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_nmi && NMI_EN && !drop_req && !wr_en) |=> $stable(any_ord));

  // R6
  nmi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_req && rpr_nmi) |-> (drop_nmi && drop_hit && drop_prio == 8'hFF));

  // R6
  nmi_drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_req && rpr_nmi && !act_valid && !wr_en) |=> (!rpr_nmi && $stable(any_ord)));

  // R7
  ord_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_req && drop_hit && !drop_nmi && !act_valid && !wr_en) |=> (rpr >= $past(rpr)));

  // R8
  empty_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_req && !drop_hit) |-> (drop_prio == 8'hFF && !drop_nmi));

  // R8
  empty_drop_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_req && !drop_hit && !act_valid && !wr_en) |=> (rpr == 8'hFF && !rpr_nmi));

  // R10
  no_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !NMI_EN |-> !rpr_nmi);

endmodule

bind act_prio_tracker act_prio_tracker_chk #(
  .PRIO_BITS (PRIO_BITS),
  .NMI_EN    (NMI_EN)
) u_chk (.*);

// File: tb/act_prio_tracker_tb.sv
module act_prio_tracker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // DUT A: 5 priority bits, NMI enabled (shift 3, one word)
  logic a_act_valid = 0, a_act_grp = 0, a_act_nmi = 0, a_drop_req = 0;
  logic [7:0] a_act_prio = 0;
  logic a_wr_en = 0, a_wr_grp = 0, a_rd_grp = 0;
  logic [0:0] a_wr_word = 0, a_rd_word = 0;
  logic [32:0] a_wr_data = 0;
  logic a_drop_hit, a_drop_grp, a_drop_nmi, a_rpr_nmi;
  logic [7:0] a_drop_prio, a_rpr;
  logic [32:0] a_rd_data;

  act_prio_tracker #(.PRIO_BITS(5), .NMI_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .act_valid(a_act_valid), .act_grp(a_act_grp), .act_prio(a_act_prio), .act_nmi(a_act_nmi),
    .drop_req(a_drop_req), .drop_hit(a_drop_hit), .drop_grp(a_drop_grp),
    .drop_nmi(a_drop_nmi), .drop_prio(a_drop_prio),
    .wr_en(a_wr_en), .wr_grp(a_wr_grp), .wr_word(a_wr_word), .wr_data(a_wr_data),
    .rd_grp(a_rd_grp), .rd_word(a_rd_word), .rd_data(a_rd_data),
    .rpr(a_rpr), .rpr_nmi(a_rpr_nmi)
  );

  // DUT B: 6 priority bits, NMI disabled (shift 2, two words)
  logic b_act_valid = 0, b_act_grp = 0, b_act_nmi = 0, b_drop_req = 0;
  logic [7:0] b_act_prio = 0;
  logic b_wr_en = 0, b_wr_grp = 0, b_rd_grp = 0;
  logic [0:0] b_wr_word = 0, b_rd_word = 0;
  logic [32:0] b_wr_data = 0;
  logic b_drop_hit, b_drop_grp, b_drop_nmi, b_rpr_nmi;
  logic [7:0] b_drop_prio, b_rpr;
  logic [32:0] b_rd_data;

  act_prio_tracker #(.PRIO_BITS(6), .NMI_EN(1'b0)) u_dut2 (
    .clk(clk), .rst_n(rst_n),
    .act_valid(b_act_valid), .act_grp(b_act_grp), .act_prio(b_act_prio), .act_nmi(b_act_nmi),
    .drop_req(b_drop_req), .drop_hit(b_drop_hit), .drop_grp(b_drop_grp),
    .drop_nmi(b_drop_nmi), .drop_prio(b_drop_prio),
    .wr_en(b_wr_en), .wr_grp(b_wr_grp), .wr_word(b_wr_word), .wr_data(b_wr_data),
    .rd_grp(b_rd_grp), .rd_word(b_rd_word), .rd_data(b_rd_data),
    .rpr(b_rpr), .rpr_nmi(b_rpr_nmi)
  );

  // Reference model of DUT A
  logic [31:0] m0 = 0, m1 = 0;
  logic        mn = 0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic int low_set(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] exp_rpr();
    int l;
    l = low_set(m0 | m1);
    if (mn) return 8'h00;
    if (l < 0) return 8'hFF;
    return 8'(l * 8);
  endfunction

  task automatic a_act(input logic g, input logic [7:0] p, input logic n);
    @(negedge clk);
    a_act_valid = 1; a_act_grp = g; a_act_prio = p; a_act_nmi = n;
    @(negedge clk);
    a_act_valid = 0; a_act_nmi = 0;
    if (n) mn = 1;
    else if (g) m1[p >> 3] = 1'b1;
    else m0[p >> 3] = 1'b1;
  endtask

  task automatic a_wr(input logic g, input logic [32:0] d);
    @(negedge clk);
    a_wr_en = 1; a_wr_grp = g; a_wr_word = 0; a_wr_data = d;
    @(negedge clk);
    a_wr_en = 0;
    if (g) begin m1 = d[31:0]; mn = d[32]; end
    else m0 = d[31:0];
  endtask

  task automatic a_drop(input string tag);
    int l;
    logic [7:0] ep;
    logic eh, en, eg;
    @(negedge clk);
    a_drop_req = 1;
    l = low_set(m0 | m1);
    if (mn) begin eh = 1; en = 1; eg = 0; ep = 8'hFF; end
    else if (l >= 0) begin eh = 1; en = 0; eg = !m0[l]; ep = 8'(l * 8); end
    else begin eh = 0; en = 0; eg = 0; ep = 8'hFF; end
    #2;
    chk({tag, " drop_hit"}, 64'(a_drop_hit), 64'(eh));
    chk({tag, " drop_nmi"}, 64'(a_drop_nmi), 64'(en));
    chk({tag, " drop_prio"}, 64'(a_drop_prio), 64'(ep));
    if (eh && !en) chk({tag, " drop_grp"}, 64'(a_drop_grp), 64'(eg));
    @(negedge clk);
    a_drop_req = 0;
    if (mn) mn = 0;
    else if (l >= 0) begin
      if (m0[l]) m0[l] = 1'b0; else m1[l] = 1'b0;
    end
  endtask

  task automatic a_state(input string tag);
    a_rd_word = 0;
    a_rd_grp = 0; #1;
    chk({tag, " word g0"}, 64'(a_rd_data), {31'b0, 1'b0, m0});
    a_rd_grp = 1; #1;
    chk({tag, " word g1"}, 64'(a_rd_data), {31'b0, mn, m1});
    chk({tag, " rpr"}, 64'({a_rpr_nmi, a_rpr}), 64'({mn, exp_rpr()}));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] x;
    repeat (3) @(negedge clk);
    // R1 reset state
    a_state("R1 reset");
    chk("R1 reset drop_hit idle", 64'(a_drop_hit), 64'(0));
    rst_n = 1;
    @(negedge clk);
    a_state("R1 after release");

    // R2 / R4 sweep: every priority, both groups
    for (int g = 0; g < 2; g++) begin
      for (int p = 0; p < 256; p++) begin
        a_wr(1'b0, 33'h0);
        a_wr(1'b1, 33'h0);
        a_act(g[0], 8'(p), 1'b0);
        a_state("R2 sweep");
        chk("R4 sweep rpr", 64'(a_rpr), 64'(p & 8'hF8));
      end
    end

    // R5 NMI over bitmap, R3 NMI sets only the flag (group 0 request)
    a_wr(1'b0, 33'h0); a_wr(1'b1, 33'h0);
    a_act(1'b1, 8'h40, 1'b0);
    a_act(1'b0, 8'h20, 1'b1);
    a_state("R3 nmi activate");
    chk("R5 rpr under nmi", 64'({a_rpr_nmi, a_rpr}), 64'({1'b1, 8'h00}));
    // R6 NMI released first
    a_drop("R6 nmi drop");
    a_state("R6 after nmi drop");
    chk("R6 ordinary level back", 64'(a_rpr), 64'(8'h40));
    // R7 tie at one index: group 0 first
    a_act(1'b0, 8'h40, 1'b0);
    a_drop("R7 tie g0");
    a_drop("R7 tie g1");
    // R8 empty drop
    a_drop("R8 empty");
    a_state("R8 after empty");
    // R9 NMI flag through write, and discarded on group 0
    a_wr(1'b1, {1'b1, 32'h0000_0100});
    a_state("R9 write g1 with flag");
    @(negedge clk);
    a_wr_en = 1; a_wr_grp = 0; a_wr_word = 0; a_wr_data = {1'b1, 32'h0000_0002};
    @(negedge clk);
    a_wr_en = 0; m0 = 32'h2;
    a_state("R9 write g0 flag discarded");
    a_drop("R9 drop after write");
    a_drop("R7 drop g0 bit1");
    a_drop("R7 drop g1 bit8");

    // Randomised mixed operations against the model
    x = 32'h1234_5678;
    for (int k = 0; k < 3000; k++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      case (x[1:0])
        2'd0, 2'd1: a_act(x[8], x[23:16], (x[7:4] == 4'h0));
        2'd2: a_drop("R7 random");
        default: if (x[6:3] == 4'h0) a_wr(x[9], {x[10], x[31:0] & {x[30:0], 1'b1}});
                 else a_drop("R6 random");
      endcase
      a_state("R4 random");
    end

    // DUT B: NMI disabled, two words
    @(negedge clk);
    b_wr_en = 1; b_wr_grp = 1; b_wr_word = 0; b_wr_data = {1'b1, 32'h0};
    @(negedge clk);
    b_wr_en = 0; b_rd_grp = 1; b_rd_word = 0; #1;
    chk("R9 flag dropped when disabled", 64'(b_rd_data), 64'(0));
    chk("R9 no nmi when disabled", 64'(b_rpr_nmi), 64'(0));
    @(negedge clk);
    b_act_valid = 1; b_act_grp = 1; b_act_prio = 8'h14; b_act_nmi = 1;
    @(negedge clk);
    b_act_valid = 0; b_act_nmi = 0; #1;
    chk("R10 nmi treated as ordinary word0", 64'(b_rd_data), 64'(33'h20));
    chk("R10 rpr", 64'({b_rpr_nmi, b_rpr}), 64'({1'b0, 8'h14}));
    @(negedge clk);
    b_act_valid = 1; b_act_grp = 0; b_act_prio = 8'h93;
    @(negedge clk);
    b_act_valid = 0; b_rd_grp = 0; b_rd_word = 1; #1;
    chk("R2 upper word bit", 64'(b_rd_data), 64'(33'h10));
    @(negedge clk);
    b_drop_req = 1; #2;
    chk("R7 two-word drop prio", 64'({b_drop_hit, b_drop_nmi, b_drop_grp, b_drop_prio}),
        64'({3'b101, 8'h14}));
    @(negedge clk);
    b_drop_req = 0; #1;
    chk("R4 two-word rpr", 64'(b_rpr), 64'(8'h90));
    @(negedge clk);
    b_wr_en = 1; b_wr_grp = 0; b_wr_word = 1; b_wr_data = {1'b1, 32'h8000_0000};
    @(negedge clk);
    b_wr_en = 0; #1;
    chk("R9 upper word write", 64'(b_rd_data), 64'(33'h0_8000_0000));
    chk("R4 rpr after upper write", 64'(b_rpr), 64'(8'hFC));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule